// File: doc/BRIEF.md
# Level-Sensitive Interrupt Aggregator with Set/Clear Enable Strobes

This block gathers 32 level-sensitive interrupt sources into two active-high interrupt request lines toward a processor. Each source line is first synchronized into the block's clock domain. It then passes through a shared enable mask and a per-source routing bit, which steers it to request line 0 or request line 1. A simple 32-bit register bus (address, write enable, write data, combinational read data) gives software access to the input levels, the masked status of each line, the routing register and the enable mask.

Software never writes the enable mask as a whole. A write to the set-strobe offset turns on the enable of every source whose written bit is one. A write to the clear-strobe offset turns off the enable of every source whose written bit is one. The top bit of the mask is not a source enable. It is a master gate that holds both request lines low while it is clear. Because the sources are level-sensitive, a pending source stays pending until its input falls or its enable is cleared.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the enable mask and the routing register are zero, both request outputs are low, and every mapped read returns zero while the source inputs are low.
- R2: A read at offset 0x30 returns the source input levels, delayed by a two-stage synchronizer (visible two clock edges after the input changes), whatever the enable mask and routing.
- R3: A write at offset 0x34 sets every enable bit whose written bit is one and leaves the bits written as zero unchanged.
- R4: A write at offset 0x38 clears every enable bit whose written bit is one and leaves the bits written as zero unchanged.
- R5: Reads at offset 0x34 and at offset 0x38 both return the current enable mask.
- R6: Offset 0x20 holds the routing register, readable and writable. A routing bit of 0 sends its source to request line 0, and a bit of 1 sends it to request line 1.
- R7: Bit i (i below 31) of the status at offset 0x00 is synchronized input i AND enable i AND NOT routing i. At offset 0x04 it is the same with routing i in place of NOT routing i. Bit 31 of both reads as zero.
- R8: Enable bit 31 is a master gate. While it is clear, both request outputs stay low even when status bits are set. The status reads are not affected by it.
- R9: Each request output is the OR of its status bits ANDed with the master gate, registered. It follows a change of status or gate one clock edge later.
- R10: A request stays asserted for as long as its source input is high and enabled. Clearing that source's enable drops it.
- R11: Writes to unmapped offsets change neither the enable mask nor the routing register, and reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Level-sensitive interrupt source inputs |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq0_o | output | 1 | Request line 0, active high |
| irq1_o | output | 1 | Request line 1, active high |

## Verification
The hardest situation to reach from the ports is a source that is pending, enabled and correctly routed while the master gate is clear. In that state the status reads show a set bit but both request lines must stay quiet. The stimulus raises the sources and enables them with a set-strobe word that leaves bit 31 at zero. It checks the status reads and the silent outputs, and only then opens the gate with a second strobe that carries bit 31 alone. This shows that the gate acts on the outputs and not on the status registers. A further sequence writes all-ones words to unmapped offsets and then reads back the mask and the routing register, which shows the writes were ignored.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int NUM_SRC = 32;
    localparam int ADDR_W  = 8;
    localparam int GATE_BIT = NUM_SRC - 1;

    localparam logic [ADDR_W-1:0] OFF_STAT0 = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_STAT1 = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_ROUTE = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_LEVEL = 8'h30;
    localparam logic [ADDR_W-1:0] OFF_SETEN = 8'h34;
    localparam logic [ADDR_W-1:0] OFF_CLREN = 8'h38;

    typedef struct packed {
        logic [NUM_SRC-1:0] en;
        logic [NUM_SRC-1:0] route;
    } cfg_t;

    typedef struct packed {
        logic req0;
        logic req1;
    } req_t;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [STAGES-1:0][WIDTH-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = d_i;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irqc_cfg.sv
module irqc_cfg
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [NUM_SRC-1:0] bus_wdata,
    output logic [NUM_SRC-1:0] en_o,
    output logic [NUM_SRC-1:0] route_o
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (bus_we) begin
            unique case (bus_addr)
                OFF_SETEN: cfg_d.en    = cfg_q.en | bus_wdata;
                OFF_CLREN: cfg_d.en    = cfg_q.en & ~bus_wdata;
                OFF_ROUTE: cfg_d.route = bus_wdata;
                default:   cfg_d       = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign en_o    = cfg_q.en;
    assign route_o = cfg_q.route;

    assert_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFF_SETEN) |=> ((en_o & $past(bus_wdata)) == $past(bus_wdata)));

    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFF_CLREN) |=> ((en_o & $past(bus_wdata)) == '0));

    assert_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_we || (bus_addr != OFF_SETEN && bus_addr != OFF_CLREN && bus_addr != OFF_ROUTE))
        |=> ($stable(en_o) && $stable(route_o)));
endmodule

// File: rtl/irqc_route.sv
module irqc_route
    import irqc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] level_i,
    input  logic [NUM_SRC-1:0] en_i,
    input  logic [NUM_SRC-1:0] route_i,
    output logic [NUM_SRC-1:0] stat0_o,
    output logic [NUM_SRC-1:0] stat1_o,
    output logic               req0_o,
    output logic               req1_o
);
    localparam logic [NUM_SRC-1:0] SRC_MASK = {1'b0, {(NUM_SRC-1){1'b1}}};

    req_t req_d, req_q;
    logic gate;

    always_comb begin
        gate    = en_i[GATE_BIT];
        stat0_o = level_i & en_i & ~route_i & SRC_MASK;
        stat1_o = level_i & en_i &  route_i & SRC_MASK;
        req_d.req0 = (|stat0_o) & gate;
        req_d.req1 = (|stat1_o) & gate;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_d;
    end

    assign req0_o = req_q.req0;
    assign req1_o = req_q.req1;

    assert_gate_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !gate |=> (!req0_o && !req1_o));

    assert_req0_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req0_o |-> ($past(gate) && $past(stat0_o) != '0));

    assert_req1_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req1_o |-> ($past(gate) && $past(stat1_o) != '0));

    assert_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat0_o & stat1_o) == '0);
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irqc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       src_i,
    input  logic [7:0]        bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq0_o,
    output logic              irq1_o
);
    logic [NUM_SRC-1:0] level, en, route, stat0, stat1;

    irqc_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (src_i),
        .q_o   (level)
    );

    irqc_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .en_o      (en),
        .route_o   (route)
    );

    irqc_route u_route (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (level),
        .en_i    (en),
        .route_i (route),
        .stat0_o (stat0),
        .stat1_o (stat1),
        .req0_o  (irq0_o),
        .req1_o  (irq1_o)
    );

    always_comb begin
        unique case (bus_addr)
            OFF_STAT0: bus_rdata = stat0;
            OFF_STAT1: bus_rdata = stat1;
            OFF_ROUTE: bus_rdata = route;
            OFF_LEVEL: bus_rdata = level;
            OFF_SETEN: bus_rdata = en;
            OFF_CLREN: bus_rdata = en;
            default:   bus_rdata = '0;
        endcase
    end

    assert_status_top_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_addr == OFF_STAT0 || bus_addr == OFF_STAT1) |-> !bus_rdata[31]));
endmodule

// File: tb/sim_irq_aggregator.sv
`timescale 1ns/1ps
module sim_irq_aggregator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_i = '0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq0_o, irq1_o;

    int total = 0;
    int bad = 0;
    logic [31:0] en_m = '0;
    logic [31:0] typ_m = '0;

    always #2.5 clk = ~clk;

    irq_aggregator u0 (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq0_o(irq0_o), .irq1_o(irq1_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
        if (a == 8'h34) en_m = en_m | d;
        else if (a == 8'h38) en_m = en_m & ~d;
        else if (a == 8'h20) typ_m = d;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] exp_st(input logic sel);
        return src_i & en_m & (sel ? typ_m : ~typ_m) & 32'h7FFF_FFFF;
    endfunction

    task automatic check_all(input string req);
        logic [31:0] v;
        rd(8'h00, v); check({req, " R7 stat0"}, v, exp_st(1'b0));
        rd(8'h04, v); check({req, " R7 stat1"}, v, exp_st(1'b1));
        rd(8'h34, v); check({req, " R5 en@34"}, v, en_m);
        rd(8'h38, v); check({req, " R5 en@38"}, v, en_m);
        rd(8'h20, v); check({req, " R6 route"}, v, typ_m);
        check({req, " R9 irq0"}, {31'b0, irq0_o}, {31'b0, (|exp_st(1'b0)) & en_m[31]});
        check({req, " R9 irq1"}, {31'b0, irq1_o}, {31'b0, (|exp_st(1'b1)) & en_m[31]});
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(8'h30, v); check("R1 level", v, 32'h0);
        check_all("R1");
    endtask

    task automatic t_level_sync;
        logic [31:0] v;
        @(negedge clk); src_i = 32'hA5A5_0F0F;
        cyc(1); rd(8'h30, v); check("R2 after one edge", v, 32'h0);
        cyc(1); rd(8'h30, v); check("R2 after two edges", v, 32'hA5A5_0F0F);
        wr(8'h20, 32'hFFFF_0000);
        rd(8'h30, v); check("R2 route-independent", v, 32'hA5A5_0F0F);
        cyc(1); check_all("R2");
    endtask

    task automatic t_set_clear;
        wr(8'h34, 32'h0000_00F0);
        wr(8'h34, 32'h0000_0003);
        cyc(1); check_all("R3 set keeps zeros");
        wr(8'h38, 32'h0000_0011);
        cyc(1); check_all("R4 clear keeps zeros");
    endtask

    task automatic t_gate;
        logic [31:0] v;
        wr(8'h20, 32'h0000_0100);
        wr(8'h34, 32'h0000_0101);
        cyc(2);
        rd(8'h00, v); check("R8 stat0 visible gate closed", v, exp_st(1'b0));
        check("R8 irq0 low gate closed", {31'b0, irq0_o}, 32'h0);
        check("R8 irq1 low gate closed", {31'b0, irq1_o}, 32'h0);
        wr(8'h34, 32'h8000_0000);
        cyc(1); check_all("R8 gate open");
        wr(8'h38, 32'h8000_0000);
        cyc(1); check_all("R8 gate closed again");
        wr(8'h34, 32'h8000_0000);
        cyc(1);
    endtask

    task automatic t_route_level;
        wr(8'h38, 32'h7FFF_FFFF);
        wr(8'h20, 32'h0000_0000);
        @(negedge clk); src_i = 32'h0000_0004;
        wr(8'h34, 32'h0000_0004);
        cyc(2); check_all("R6 route to line0");
        check("R6 irq0 high", {31'b0, irq0_o}, 32'h1);
        wr(8'h20, 32'h0000_0004);
        cyc(1); check_all("R6 route to line1");
        check("R6 irq1 high", {31'b0, irq1_o}, 32'h1);
        cyc(10);
        check("R10 level holds", {31'b0, irq1_o}, 32'h1);
        wr(8'h38, 32'h0000_0004);
        cyc(1);
        check("R10 mask drops", {31'b0, irq1_o}, 32'h0);
        check_all("R10");
        wr(8'h34, 32'h0000_0004);
        @(negedge clk); src_i = 32'h0;
        cyc(3);
        check("R10 input low drops", {31'b0, irq1_o}, 32'h0);
        src_i = 32'h8000_0000;
        cyc(3); check_all("R7 source31 never pending");
    endtask

    task automatic t_unmapped;
        logic [31:0] v;
        wr(8'h10, 32'hFFFF_FFFF);
        wr(8'h3C, 32'hFFFF_FFFF);
        wr(8'h24, 32'hFFFF_FFFF);
        cyc(1); check_all("R11 writes ignored");
        rd(8'h10, v); check("R11 read 0x10", v, 32'h0);
        rd(8'h3C, v); check("R11 read 0x3C", v, 32'h0);
        rd(8'hFC, v); check("R11 read 0xFC", v, 32'h0);
    endtask

    initial begin
        fork
            begin
                cyc(3); rst_n = 1'b1; cyc(1);
                t_reset();
                t_level_sync();
                t_set_clear();
                t_gate();
                t_route_level();
                t_unmapped();
            end
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule